// File: doc/BRIEF.md
# Capture/Reload Timer-Counter

This block is a timer-counter whose width is set by a parameter (16 bits by default). It sits next to a 16-bit capture/reload register pair. A run bit, a baud-clock select and a capture/reload select choose one of four modes:

- **off**
- **auto-reload**: on overflow the count restarts from the register pair.
- **capture**: a trigger edge copies the running count into the register pair.
- **baud-rate generation**: the count runs at half the oscillator rate and emits a one-clock tick each time it reloads.

In the two timer modes the count advances in one of two ways. It takes one step per machine cycle, or it steps on qualified falling edges of an external count pin. A second pin, the trigger, starts a capture or a reload. The trigger's falling edges are found the same way as the count pin's.

A free-running slot counter divides each machine cycle into 12 oscillator clocks: 6 states of 2 phases each. Slot number = 2·(state−1) + (phase−1).
- Both pins are sampled once per machine cycle, in slot 9 (state 5, phase 2).
- Count steps and trigger actions take effect in slot 4 (state 3, phase 1).

Two sticky flags record events:
- the overflow flag;
- the external-event flag.

The interrupt request is the OR of the two flags. Only the software clear inputs lower them.

Top module: `capreload_timer`

## Requirements
- R1: After reset the count, the register pair, both flags, the interrupt request and the baud tick are 0. The slot counter is at slot 0 and advances by one per clock from the first edge after reset is released.
- R2: With run_en=0 the block is off whatever baud_sel and cap_sel hold. The count, the register pair and both flags hold their values, and edges on either pin have no effect.
- R3: In auto-reload or capture mode with ext_mode=0, the count steps by one per machine cycle. The new value appears on the clock edge that leaves slot 4 and on no other edge.
- R4: In auto-reload mode, a step taken while the count is all ones loads the register pair into the count and sets the overflow flag.
- R5: In capture mode, a step taken while the count is all ones wraps the count to 0 and sets the overflow flag. The register pair is left alone unless a trigger occurs.
- R6: With ext_mode=1 the count pin is sampled in slot 9 of each machine cycle (after a 2-flop synchroniser). The count steps only when one sample is 1 and the next sample is 0. The step appears on the edge that leaves slot 4 of the following machine cycle. Levels that change and return between two samples are not counted, and at most one step occurs every two machine cycles.
- R7: In capture mode with trig_en=1, a trigger falling edge (sampled as in R6) copies the count, as it stood before that machine cycle's step, into the register pair and sets the external-event flag. The count keeps stepping.
- R8: In auto-reload mode with trig_en=1, a trigger falling edge loads the register pair into the count in place of that cycle's step and sets the external-event flag.
- R9: With trig_en=0, trigger edges change neither the count, nor the register pair, nor the external-event flag.
- R10: In baud mode (run_en=1, baud_sel=1) cap_sel has no effect. The count steps every 2 clocks. At all ones it reloads from the register pair and raises baud_tick for exactly one clock. The overflow flag is never set. A trigger edge with trig_en=1 sets only the external-event flag.
- R11: irq is 1 exactly when either flag is 1. A flag stays set until its clear input is 1 at a clock edge. When a set and a clear meet in the same clock, the set wins.
- R12: cnt_wr loads cnt_wdata into the count and pair_wr loads pair_wdata into the register pair. Each wins over any hardware update of the same register in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| run_en | input | 1 | Run bit; 0 turns the block off |
| baud_sel | input | 1 | Selects baud-rate generation |
| cap_sel | input | 1 | 1 = capture, 0 = auto-reload |
| ext_mode | input | 1 | 1 = count falling edges on cnt_pin |
| trig_en | input | 1 | Enables the trigger pin |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | External capture/reload trigger |
| cnt_wr | input | 1 | Software write strobe for the count |
| cnt_wdata | input | CNT_W | Value written to the count |
| pair_wr | input | 1 | Software write strobe for the register pair |
| pair_wdata | input | CNT_W | Value written to the register pair |
| clr_ovf | input | 1 | Software clear of the overflow flag |
| clr_ext | input | 1 | Software clear of the external-event flag |
| count | output | CNT_W | Current count |
| pair | output | CNT_W | Capture/reload register pair |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External-event flag |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-clock pulse on each baud reload |

## Verification
The bench builds the block with CNT_W=4 and keeps the defaults of 6 states per machine cycle and 2 synchroniser stages. At 4 bits, every start value of the count can be swept in both timer modes against several register-pair values. The all-ones wrap and reload are then reached within a few machine cycles. Baud reload periods also become short enough to count exact tick totals over a fixed window. With the real machine-cycle length kept, the slot-exact timing of sampling, stepping, triggering and write priority is checked as it would run at full width.

// File: rtl/ctr2_pkg.sv
package ctr2_pkg;

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_RELOAD,
        MODE_CAPTURE,
        MODE_BAUD
    } tmode_e;

    typedef enum logic [1:0] {
        EQ_IDLE,
        EQ_ARMED,
        EQ_PENDING
    } eq_state_e;

    function automatic tmode_e decode_mode(input logic run, input logic baud, input logic capsel);
        tmode_e m;
        if (!run)
            m = MODE_OFF;
        else if (baud)
            m = MODE_BAUD;
        else if (capsel)
            m = MODE_CAPTURE;
        else
            m = MODE_RELOAD;
        return m;
    endfunction

endpackage

// File: rtl/ctr2_phase_gen.sv
module ctr2_phase_gen #(
    parameter int STATES    = 6,
    parameter int SMP_STATE = 5,
    parameter int UPD_STATE = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic smp_stb,
    output logic upd_stb,
    output logic half_stb
);
    localparam int SLOTS   = 2 * STATES;
    localparam int PH_W    = $clog2(SLOTS);
    localparam int SMP_IDX = (SMP_STATE - 1) * 2 + 1;
    localparam int UPD_IDX = (UPD_STATE - 1) * 2;

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ph <= '0;
        else if (ph == PH_W'(SLOTS - 1))
            ph <= '0;
        else
            ph <= ph + 1'b1;
    end

    always_comb begin
        smp_stb  = (ph == PH_W'(SMP_IDX));
        upd_stb  = (ph == PH_W'(UPD_IDX));
        half_stb = ph[0];
    end
endmodule

// File: rtl/ctr2_edge_qual.sv
module ctr2_edge_qual
    import ctr2_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic smp_stb,
    input  logic upd_stb,
    output logic fire
);
    logic      pin_s;
    eq_state_e state_q, state_d;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign pin_s = pin;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain[0] <= pin;
                    for (int i = 1; i < SYNC_STAGES; i++)
                        chain[i] <= chain[i-1];
                end
            end
            assign pin_s = chain[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= EQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EQ_IDLE:    if (smp_stb && pin_s)  state_d = EQ_ARMED;
            EQ_ARMED:   if (smp_stb && !pin_s) state_d = EQ_PENDING;
            EQ_PENDING: if (upd_stb)           state_d = EQ_IDLE;
            default:                           state_d = EQ_IDLE;
        endcase
    end

    always_comb begin
        fire = (state_q == EQ_PENDING) && upd_stb;
    end
endmodule

// File: rtl/ctr2_core.sv
module ctr2_core
    import ctr2_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmode_e           mode,
    input  logic             ext_mode,
    input  logic             trig_en,
    input  logic             upd_stb,
    input  logic             half_stb,
    input  logic             cnt_fire,
    input  logic             trig_fire,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             pair_wr,
    input  logic [CNT_W-1:0] pair_wdata,
    input  logic             clr_ovf,
    input  logic             clr_ext,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] pair,
    output logic             ovf_flag,
    output logic             ext_flag,
    output logic             baud_tick
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, pair_d;
    logic             ovf_set, ext_set, tick_d;
    logic             advance, trig_hit, at_max;

    always_comb begin
        advance  = ext_mode ? cnt_fire : upd_stb;
        trig_hit = trig_fire && trig_en;
        at_max   = (count == CNT_MAX);
        cnt_d    = count;
        pair_d   = pair;
        ovf_set  = 1'b0;
        ext_set  = 1'b0;
        tick_d   = 1'b0;
        unique case (mode)
            MODE_OFF: begin
            end
            MODE_RELOAD: begin
                if (trig_hit) begin
                    cnt_d   = pair;
                    ext_set = 1'b1;
                end else if (advance) begin
                    if (at_max) begin
                        cnt_d   = pair;
                        ovf_set = 1'b1;
                    end else begin
                        cnt_d = count + 1'b1;
                    end
                end
            end
            MODE_CAPTURE: begin
                if (advance) begin
                    cnt_d   = count + 1'b1;
                    ovf_set = at_max;
                end
                if (trig_hit) begin
                    pair_d  = count;
                    ext_set = 1'b1;
                end
            end
            MODE_BAUD: begin
                if (half_stb) begin
                    if (at_max) begin
                        cnt_d  = pair;
                        tick_d = 1'b1;
                    end else begin
                        cnt_d = count + 1'b1;
                    end
                end
                if (trig_hit)
                    ext_set = 1'b1;
            end
            default: begin
            end
        endcase
        if (cnt_wr)
            cnt_d = cnt_wdata;
        if (pair_wr)
            pair_d = pair_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= '0;
            pair      <= '0;
            ovf_flag  <= 1'b0;
            ext_flag  <= 1'b0;
            baud_tick <= 1'b0;
        end else begin
            count     <= cnt_d;
            pair      <= pair_d;
            baud_tick <= tick_d;
            if (ovf_set)
                ovf_flag <= 1'b1;
            else if (clr_ovf)
                ovf_flag <= 1'b0;
            if (ext_set)
                ext_flag <= 1'b1;
            else if (clr_ext)
                ext_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/capreload_timer.sv
module capreload_timer
    import ctr2_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int STATES      = 6,
    parameter int SMP_STATE   = 5,
    parameter int UPD_STATE   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             baud_sel,
    input  logic             cap_sel,
    input  logic             ext_mode,
    input  logic             trig_en,
    input  logic             cnt_pin,
    input  logic             trig_pin,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             pair_wr,
    input  logic [CNT_W-1:0] pair_wdata,
    input  logic             clr_ovf,
    input  logic             clr_ext,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] pair,
    output logic             ovf_flag,
    output logic             ext_flag,
    output logic             irq,
    output logic             baud_tick
);
    logic   smp_stb, upd_stb, half_stb;
    logic   cnt_fire, trig_fire;
    tmode_e mode;

    always_comb mode = decode_mode(run_en, baud_sel, cap_sel);

    ctr2_phase_gen #(
        .STATES    (STATES),
        .SMP_STATE (SMP_STATE),
        .UPD_STATE (UPD_STATE)
    ) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_stb  (smp_stb),
        .upd_stb  (upd_stb),
        .half_stb (half_stb)
    );

    ctr2_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) cnt_eq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (cnt_pin),
        .smp_stb (smp_stb),
        .upd_stb (upd_stb),
        .fire    (cnt_fire)
    );

    ctr2_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) trig_eq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (trig_pin),
        .smp_stb (smp_stb),
        .upd_stb (upd_stb),
        .fire    (trig_fire)
    );

    ctr2_core #(.CNT_W(CNT_W)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .ext_mode   (ext_mode),
        .trig_en    (trig_en),
        .upd_stb    (upd_stb),
        .half_stb   (half_stb),
        .cnt_fire   (cnt_fire),
        .trig_fire  (trig_fire),
        .cnt_wr     (cnt_wr),
        .cnt_wdata  (cnt_wdata),
        .pair_wr    (pair_wr),
        .pair_wdata (pair_wdata),
        .clr_ovf    (clr_ovf),
        .clr_ext    (clr_ext),
        .count      (count),
        .pair       (pair),
        .ovf_flag   (ovf_flag),
        .ext_flag   (ext_flag),
        .baud_tick  (baud_tick)
    );

    assign irq = ovf_flag | ext_flag;
endmodule

// File: rtl/ctr2_checker.sv
module ctr2_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             baud_sel,
    input logic             cnt_wr,
    input logic             clr_ovf,
    input logic             clr_ext,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag,
    input logic             ext_flag,
    input logic             baud_tick
);
    // R2: an idle block keeps its count unless software writes it
    a_r2_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cnt_wr) |=> $stable(count));

    // R10: baud mode never raises the overflow flag
    a_r10_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && baud_sel && !ovf_flag) |=> !ovf_flag);

    // R10: the baud tick lasts one clock
    a_r10_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);

    // R11: overflow flag is sticky until cleared
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    // R11: external-event flag is sticky until cleared
    a_r11_ext_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_flag && !clr_ext) |=> ext_flag);
endmodule

bind capreload_timer ctr2_checker #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .baud_sel  (baud_sel),
    .cnt_wr    (cnt_wr),
    .clr_ovf   (clr_ovf),
    .clr_ext   (clr_ext),
    .count     (count),
    .ovf_flag  (ovf_flag),
    .ext_flag  (ext_flag),
    .baud_tick (baud_tick)
);

// File: tb/capreload_timer_tb_top.sv
module capreload_timer_tb_top;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0, baud_sel = 1'b0, cap_sel = 1'b0, ext_mode = 1'b0, trig_en = 1'b0;
    logic cnt_pin = 1'b1, trig_pin = 1'b1;
    logic cnt_wr = 1'b0, pair_wr = 1'b0, clr_ovf = 1'b0, clr_ext = 1'b0;
    logic [W-1:0] cnt_wdata = '0, pair_wdata = '0;
    logic [W-1:0] count, pair;
    logic ovf_flag, ext_flag, irq, baud_tick;

    int n_tests = 0;
    int n_fail = 0;
    int ph_b = 0;

    always #10 clk = ~clk;

    capreload_timer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .baud_sel(baud_sel),
        .cap_sel(cap_sel), .ext_mode(ext_mode), .trig_en(trig_en),
        .cnt_pin(cnt_pin), .trig_pin(trig_pin), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .pair_wr(pair_wr), .pair_wdata(pair_wdata),
        .clr_ovf(clr_ovf), .clr_ext(clr_ext), .count(count), .pair(pair),
        .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq), .baud_tick(baud_tick)
    );

    // slot reference: 12 slots per machine cycle, slot 0 at reset
    always @(posedge clk) begin
        if (!rst_n) ph_b <= 0;
        else        ph_b <= (ph_b == 11) ? 0 : ph_b + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic align(input int s);
        forever begin
            @(negedge clk);
            if (ph_b == s) break;
        end
    endtask

    task automatic wr_cnt(input int v);
        cnt_wdata = W'(v); cnt_wr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic wr_pair(input int v);
        pair_wdata = W'(v); pair_wr = 1'b1;
        @(negedge clk);
        pair_wr = 1'b0;
    endtask

    task automatic clear_flags();
        clr_ovf = 1'b1; clr_ext = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0; clr_ext = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int ev, eo, pv, ticks;
        wait_n(3);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 count", int'(count), 0);
        check("R1 pair", int'(pair), 0);
        check("R1 ovf", int'(ovf_flag), 0);
        check("R1 ext", int'(ext_flag), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 tick", int'(baud_tick), 0);

        // R3/R4 auto-reload sweep
        for (int p = 0; p < 3; p++) begin
            pv = (p == 0) ? 0 : (p == 1) ? 5 : 14;
            for (int s = 0; s < 16; s++) begin
                ev = s; eo = 0;
                run_en = 1'b0;
                wr_pair(pv); wr_cnt(s); clear_flags();
                align(5); run_en = 1'b1;
                for (int k = 0; k < 5; k++) begin
                    wait_n(12);
                    if (ev == 15) begin ev = pv; eo = 1; end
                    else ev = ev + 1;
                    check("R3/R4 reload count", int'(count), ev);
                end
                check("R4 ovf", int'(ovf_flag), eo);
                check("R11 irq", int'(irq), eo);
                run_en = 1'b0;
                @(negedge clk);
            end
        end

        // R5 capture sweep
        cap_sel = 1'b1;
        for (int s = 0; s < 16; s++) begin
            ev = s; eo = 0;
            wr_pair(7); wr_cnt(s); clear_flags();
            align(5); run_en = 1'b1;
            for (int k = 0; k < 4; k++) begin
                wait_n(12);
                if (ev == 15) eo = 1;
                ev = (ev + 1) % 16;
                check("R5 capture count", int'(count), ev);
            end
            check("R5 ovf", int'(ovf_flag), eo);
            check("R5 pair", int'(pair), 7);
            run_en = 1'b0;
            @(negedge clk);
        end

        // R2 off
        clear_flags(); wr_cnt(7); wr_pair(3);
        baud_sel = 1'b1; cap_sel = 1'b1; trig_en = 1'b1;
        trig_pin = 1'b0; cnt_pin = 1'b0; wait_n(24);
        trig_pin = 1'b1; cnt_pin = 1'b1; wait_n(24);
        check("R2 count", int'(count), 7);
        check("R2 pair", int'(pair), 3);
        check("R2 ext", int'(ext_flag), 0);
        baud_sel = 1'b0; cap_sel = 1'b0; trig_en = 1'b0;

        // R6 external counting
        ext_mode = 1'b1;
        wr_pair(0); wr_cnt(0);
        align(5); run_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            cnt_pin = 1'b0; wait_n(12);
            check("R6 edge count", int'(count), i + 1);
            cnt_pin = 1'b1; wait_n(12);
            check("R6 no extra", int'(count), i + 1);
        end
        align(11); cnt_pin = 1'b0;
        wait_n(4); cnt_pin = 1'b1;
        wait_n(36);
        check("R6 short pulse", int'(count), 6);
        run_en = 1'b0; ext_mode = 1'b0;

        // R7 capture trigger
        cap_sel = 1'b1; trig_en = 1'b1;
        wr_pair(0); wr_cnt(3); clear_flags();
        align(5); run_en = 1'b1;
        wait_n(24);
        check("R7 pre count", int'(count), 5);
        trig_pin = 1'b0; wait_n(12);
        check("R7 count", int'(count), 6);
        check("R7 pair", int'(pair), 5);
        check("R7 ext", int'(ext_flag), 1);
        check("R11 irq ext", int'(irq), 1);
        trig_pin = 1'b1; wait_n(12);
        check("R7 count after", int'(count), 7);
        check("R11 ext sticky", int'(ext_flag), 1);
        clear_flags();
        check("R11 ext cleared", int'(ext_flag), 0);
        check("R11 irq cleared", int'(irq), 0);
        run_en = 1'b0;

        // R8 reload trigger
        cap_sel = 1'b0;
        wr_pair(9); wr_cnt(2);
        align(5); run_en = 1'b1;
        wait_n(12);
        check("R8 pre count", int'(count), 3);
        trig_pin = 1'b0; wait_n(12);
        check("R8 reload", int'(count), 9);
        check("R8 ext", int'(ext_flag), 1);
        trig_pin = 1'b1; wait_n(12);
        check("R8 count after", int'(count), 10);
        run_en = 1'b0; clear_flags();

        // R9 trigger disabled
        cap_sel = 1'b1; trig_en = 1'b0;
        wr_pair(1); wr_cnt(4);
        align(5); run_en = 1'b1;
        trig_pin = 1'b0; wait_n(12);
        check("R9 cap count", int'(count), 5);
        check("R9 pair", int'(pair), 1);
        check("R9 ext", int'(ext_flag), 0);
        trig_pin = 1'b1; wait_n(12);
        cap_sel = 1'b0;
        trig_pin = 1'b0; wait_n(12);
        check("R9 no reload", int'(count), 7);
        check("R9 ext reload", int'(ext_flag), 0);
        trig_pin = 1'b1; run_en = 1'b0; wait_n(12);

        // R10 baud generation
        for (int cs = 0; cs < 2; cs++) begin
            cap_sel = cs[0]; trig_en = 1'b1;
            wr_pair(12); wr_cnt(12); clear_flags();
            run_en = 1'b1; baud_sel = 1'b1;
            wait_n(4);
            ticks = 0;
            for (int t = 0; t < 80; t++) begin
                @(negedge clk);
                if (baud_tick) ticks++;
            end
            check("R10 ticks", ticks, 10);
            check("R10 no ovf", int'(ovf_flag), 0);
            trig_pin = 1'b0; wait_n(24);
            check("R10 ext", int'(ext_flag), 1);
            check("R10 pair", int'(pair), 12);
            trig_pin = 1'b1; wait_n(12);
            run_en = 1'b0; baud_sel = 1'b0;
            @(negedge clk);
        end
        trig_en = 1'b0;

        // R11 set beats clear
        cap_sel = 1'b1;
        wr_cnt(15); clear_flags();
        align(5); clr_ovf = 1'b1; run_en = 1'b1;
        wait_n(12);
        check("R11 set wins", int'(ovf_flag), 1);
        @(negedge clk);
        check("R11 clear", int'(ovf_flag), 0);
        clr_ovf = 1'b0; run_en = 1'b0;

        // R12 write priority, R3 slot timing
        cap_sel = 1'b0;
        wr_pair(0); wr_cnt(2);
        align(5); run_en = 1'b1;
        align(4);
        cnt_wdata = 4'd11; cnt_wr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0;
        check("R12 write wins", int'(count), 11);
        wait_n(11);
        check("R3 before slot4 edge", int'(count), 11);
        @(negedge clk);
        check("R3 after slot4 edge", int'(count), 12);
        run_en = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule